// File: doc/BRIEF.md
# Multi-Strip Frame Memory Scan Address Generator

This block turns line and pixel strobes from a display timing generator into the stream of word addresses to fetch from an external frame memory, one address for each displayed pixel of an RGB TFT panel. Each pixel is one 16-bit word. The panel is cut into horizontal strips. Each strip reads from its own start address with its own line pitch, so one strip can show a fixed control area while another is a movable window into a wider source image.

Several whole frames sit back to back in memory, each `FRAME_W * FRAME_H` words long, and one of them is chosen as the displayed source. A pan offset moves the panel window inside a frame that is larger than the panel. The scan can be reversed horizontally and vertically. All settings are written into shadow registers and checked as they arrive. A rejected write raises an error pulse and changes nothing. Accepted settings reach the scan only when a vertical blanking strobe arrives, so a displayed frame never mixes two configurations.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset `addr_valid_o` and `cfg_err_o` are 0 and `frame_o` is 0. The active setup is one strip (index 0) covering all `PANEL_H` lines at offset 0 with a pitch of `FRAME_W`, no pan, and no reversal.
- R2: After a `line_start` strobe, and one clock edge later, `addr_valid_o` is high and `addr_o` equals frame*`FRAME_W*FRAME_H` + strip start + (row in strip + pan_y)*pitch + column + pan_x, taken modulo 2^`ADDR_W`. Each `pix_adv` moves to the next column. After `PANEL_W` advances the valid flag goes low.
- R3: Scan line s (0 = first after `vblank_start`) reads memory row `PANEL_H-1-s` when vertical reversal is off, and row s when it is on. Strip 0 holds memory rows 0 up to its line count minus one, strip 1 holds the rows after that, and so on. So strip 0 is at the bottom of the screen without reversal and at the top with it. The row in a strip is the memory row minus the strip's first row.
- R4: With horizontal reversal, pixel p of a line reads column `PANEL_W-1-p`, so a line is fetched from right to left.
- R5: A memory row that lies beyond the sum of all strip line counts yields `addr_valid_o` low for the whole line.
- R6: A strip write whose start address has bit 0 set is rejected. `cfg_err_o` pulses high in the cycle after the write, and the strip keeps its previous settings.
- R7: A strip write is rejected with `cfg_err_o` if its index is `N_REGIONS` or more, if its line count is 0 or more than `PANEL_H`, or if it would make the total of all strip line counts exceed `PANEL_H`.
- R8: A pan write is rejected with `cfg_err_o` if x > `FRAME_W-PANEL_W` or y > `FRAME_H-PANEL_H`. When the frame has the same size as the panel, only (0,0) is accepted.
- R9: A frame select of `N_FRAMES` or more is rejected with `cfg_err_o`. `frame_o` shows the index of the frame being displayed.
- R10: Accepted strip, pan, frame and reversal writes change neither `addr_o` nor `frame_o` until the next `vblank_start`. They then apply from the first line of the new frame.
- R11: Line strobes beyond the `PANEL_H`-th in a frame produce no valid addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vblank_start | input | 1 | Start of vertical blanking: commits shadows, restarts line count |
| line_start | input | 1 | Start of a displayed line |
| pix_adv | input | 1 | Advance to the next pixel of the line |
| cfg_region_we | input | 1 | Strip write strobe |
| cfg_region_idx | input | RIW | Strip index |
| cfg_region_lines | input | LW | Strip line count |
| cfg_region_base | input | ADDR_W | Strip start word address (must be even) |
| cfg_region_stride | input | ADDR_W | Strip line pitch in pixels |
| cfg_frame_we | input | 1 | Frame select write strobe |
| cfg_frame_sel | input | FSW | Frame index |
| cfg_pan_we | input | 1 | Pan write strobe |
| cfg_pan_x | input | CW | Horizontal pan offset |
| cfg_pan_y | input | CW | Vertical pan offset |
| cfg_mode_we | input | 1 | Scan order write strobe |
| cfg_flip_h | input | 1 | Horizontal reversal |
| cfg_flip_v | input | 1 | Vertical reversal |
| addr_o | output | ADDR_W | Pixel word address |
| addr_valid_o | output | 1 | Address is a pixel to fetch |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected write |
| frame_o | output | FSW | Displayed frame index |

## Verification
The bench builds the block with a 4x4 panel inside a 6x5 frame, two frames and two strips. This makes both pan limits small enough to cross (x above 2, y above 1) and lets one strip write overflow the line total. Two strips of two lines, and later one and two lines, bring the bottom and top placement, the row-within-strip arithmetic and the unmapped-row gap within a single 4-line frame. A second copy, with the frame equal to the panel and a single strip and frame, covers the case where only the origin is accepted as a pan offset.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
   function automatic int width_for(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   typedef struct packed {
      logic flip_h;
      logic flip_v;
   } scan_order_t;
endpackage

// File: rtl/fbscan_cfg_bank.sv
module fbscan_cfg_bank
   import fbscan_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int PANEL_W   = 16,
   parameter int PANEL_H   = 12,
   parameter int FRAME_W   = 24,
   parameter int FRAME_H   = 16,
   parameter int N_FRAMES  = 3,
   parameter int N_REGIONS = 4,
   localparam int RIW = width_for(N_REGIONS + 1),
   localparam int FSW = width_for(N_FRAMES + 1),
   localparam int LW  = width_for(PANEL_H + 1),
   localparam int CW  = width_for(((FRAME_W > FRAME_H) ? FRAME_W : FRAME_H) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              region_we,
   input  logic [RIW-1:0]    region_idx,
   input  logic [LW-1:0]     region_lines,
   input  logic [ADDR_W-1:0] region_base,
   input  logic [ADDR_W-1:0] region_stride,
   input  logic              frame_we,
   input  logic [FSW-1:0]    frame_sel,
   input  logic              pan_we,
   input  logic [CW-1:0]     pan_x,
   input  logic [CW-1:0]     pan_y,
   input  logic              mode_we,
   input  scan_order_t       mode_in,
   output logic [LW-1:0]     act_lines  [N_REGIONS],
   output logic [ADDR_W-1:0] act_base   [N_REGIONS],
   output logic [ADDR_W-1:0] act_stride [N_REGIONS],
   output logic [FSW-1:0]    act_frame,
   output logic [CW-1:0]     act_pan_x,
   output logic [CW-1:0]     act_pan_y,
   output scan_order_t       act_order,
   output logic              err_o
);
   localparam int PAN_X_MAX = FRAME_W - PANEL_W;
   localparam int PAN_Y_MAX = FRAME_H - PANEL_H;
   localparam int SUMW      = LW + RIW;

   logic [LW-1:0]     sh_lines  [N_REGIONS];
   logic [ADDR_W-1:0] sh_base   [N_REGIONS];
   logic [ADDR_W-1:0] sh_stride [N_REGIONS];
   logic [FSW-1:0]    sh_frame;
   logic [CW-1:0]     sh_pan_x, sh_pan_y;
   scan_order_t       sh_order;
   logic [SUMW-1:0]   sum_new;
   logic              region_ok, frame_ok, pan_ok;

   // total line count as it would be after this write
   always_comb begin
      sum_new = '0;
      for (int k = 0; k < N_REGIONS; k++)
         sum_new += SUMW'((RIW'(k) == region_idx) ? region_lines : sh_lines[k]);
   end

   assign region_ok = (int'(region_idx) < N_REGIONS) && (region_lines != '0) &&
                      (int'(region_lines) <= PANEL_H) && (int'(sum_new) <= PANEL_H) &&
                      !region_base[0];
   assign frame_ok  = int'(frame_sel) < N_FRAMES;
   assign pan_ok    = (int'(pan_x) <= PAN_X_MAX) && (int'(pan_y) <= PAN_Y_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_REGIONS; k++) begin
            sh_lines[k]   <= (k == 0) ? LW'(PANEL_H) : '0;
            sh_base[k]    <= '0;
            sh_stride[k]  <= ADDR_W'(FRAME_W);
            act_lines[k]  <= (k == 0) ? LW'(PANEL_H) : '0;
            act_base[k]   <= '0;
            act_stride[k] <= ADDR_W'(FRAME_W);
         end
         sh_frame  <= '0;  act_frame <= '0;
         sh_pan_x  <= '0;  act_pan_x <= '0;
         sh_pan_y  <= '0;  act_pan_y <= '0;
         sh_order  <= '0;  act_order <= '0;
         err_o     <= 1'b0;
      end else begin
         err_o <= (region_we && !region_ok) || (frame_we && !frame_ok) || (pan_we && !pan_ok);
         for (int k = 0; k < N_REGIONS; k++) begin
            if (region_we && region_ok && (RIW'(k) == region_idx)) begin
               sh_lines[k]  <= region_lines;
               sh_base[k]   <= region_base;
               sh_stride[k] <= region_stride;
            end
         end
         if (frame_we && frame_ok) sh_frame <= frame_sel;
         if (pan_we && pan_ok) begin
            sh_pan_x <= pan_x;
            sh_pan_y <= pan_y;
         end
         if (mode_we) sh_order <= mode_in;
         if (commit) begin
            act_lines  <= sh_lines;
            act_base   <= sh_base;
            act_stride <= sh_stride;
            act_frame  <= sh_frame;
            act_pan_x  <= sh_pan_x;
            act_pan_y  <= sh_pan_y;
            act_order  <= sh_order;
         end
      end
   end

   a_r9_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we && (int'(frame_sel) >= N_FRAMES) |=> err_o);
   a_r10_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_frame) && $stable(act_pan_x) && $stable(act_pan_y));
   a_r8_pan_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(act_pan_x) <= PAN_X_MAX) && (int'(act_pan_y) <= PAN_Y_MAX));
endmodule

// File: rtl/fbscan_raster.sv
module fbscan_raster
   import fbscan_pkg::*;
#(
   parameter int PANEL_W = 16,
   parameter int PANEL_H = 12,
   localparam int RW  = width_for(PANEL_H),
   localparam int CXW = width_for(PANEL_W),
   localparam int NW  = width_for(PANEL_H + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_start,
   input  logic           line_start,
   input  logic           pix_adv,
   input  scan_order_t    order,
   output logic [RW-1:0]  mem_row,
   output logic [CXW-1:0] mem_col,
   output logic           line_live,
   output logic           last_pix
);
   logic [NW-1:0]  seen_q;
   logic [CXW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= '0;
         left_q    <= '0;
         mem_row   <= '0;
         mem_col   <= '0;
         line_live <= 1'b0;
      end else if (frame_start) begin
         seen_q    <= '0;
         line_live <= 1'b0;
      end else if (line_start) begin
         line_live <= int'(seen_q) < PANEL_H;
         if (int'(seen_q) < PANEL_H) begin
            seen_q  <= seen_q + NW'(1);
            mem_row <= order.flip_v ? RW'(seen_q) : RW'(PANEL_H - 1 - int'(seen_q));
         end
         mem_col <= order.flip_h ? CXW'(PANEL_W - 1) : '0;
         left_q  <= CXW'(PANEL_W - 1);
      end else if (pix_adv && line_live) begin
         if (left_q == '0) begin
            line_live <= 1'b0;
         end else begin
            left_q  <= left_q - CXW'(1);
            mem_col <= order.flip_h ? mem_col - CXW'(1) : mem_col + CXW'(1);
         end
      end
   end

   assign last_pix = line_live && (left_q == '0);

   a_r2_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_adv && !line_start && !frame_start |=> $stable(mem_col) && $stable(mem_row));
   a_r2_line_end: assert property (@(posedge clk) disable iff (!rst_n)
      last_pix && pix_adv && !line_start && !frame_start |=> !line_live);
   a_r11_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && !frame_start && (int'(seen_q) == PANEL_H) |=> !line_live);
endmodule

// File: rtl/fbscan_addr_map.sv
module fbscan_addr_map
   import fbscan_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int PANEL_W   = 16,
   parameter int PANEL_H   = 12,
   parameter int FRAME_W   = 24,
   parameter int FRAME_H   = 16,
   parameter int N_FRAMES  = 3,
   parameter int N_REGIONS = 4,
   localparam int FSW = width_for(N_FRAMES + 1),
   localparam int LW  = width_for(PANEL_H + 1),
   localparam int CW  = width_for(((FRAME_W > FRAME_H) ? FRAME_W : FRAME_H) + 1),
   localparam int RW  = width_for(PANEL_H),
   localparam int CXW = width_for(PANEL_W),
   localparam int FRAME_WORDS = FRAME_W * FRAME_H
) (
   input  logic [RW-1:0]     mem_row,
   input  logic [CXW-1:0]    mem_col,
   input  logic              line_live,
   input  logic [LW-1:0]     lines  [N_REGIONS],
   input  logic [ADDR_W-1:0] base   [N_REGIONS],
   input  logic [ADDR_W-1:0] stride [N_REGIONS],
   input  logic [FSW-1:0]    frame,
   input  logic [CW-1:0]     pan_x,
   input  logic [CW-1:0]     pan_y,
   output logic [ADDR_W-1:0] addr,
   output logic              valid
);
   logic              hit;
   int                first_row, rel_row;
   logic [ADDR_W-1:0] sel_base, sel_stride;

   // strips are stacked in index order starting at memory row 0
   always_comb begin
      hit        = 1'b0;
      first_row  = 0;
      rel_row    = 0;
      sel_base   = '0;
      sel_stride = '0;
      for (int k = 0; k < N_REGIONS; k++) begin
         if (!hit && (int'(mem_row) >= first_row) &&
             (int'(mem_row) < first_row + int'(lines[k]))) begin
            hit        = 1'b1;
            rel_row    = int'(mem_row) - first_row;
            sel_base   = base[k];
            sel_stride = stride[k];
         end
         first_row += int'(lines[k]);
      end
   end

   assign addr  = ADDR_W'(int'(frame) * FRAME_WORDS) + sel_base +
                  ADDR_W'(rel_row + int'(pan_y)) * sel_stride +
                  ADDR_W'(int'(mem_col) + int'(pan_x));
   assign valid = line_live && hit;
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
   import fbscan_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int PANEL_W   = 16,
   parameter int PANEL_H   = 12,
   parameter int FRAME_W   = 24,
   parameter int FRAME_H   = 16,
   parameter int N_FRAMES  = 3,
   parameter int N_REGIONS = 4,
   localparam int RIW = width_for(N_REGIONS + 1),
   localparam int FSW = width_for(N_FRAMES + 1),
   localparam int LW  = width_for(PANEL_H + 1),
   localparam int CW  = width_for(((FRAME_W > FRAME_H) ? FRAME_W : FRAME_H) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank_start,
   input  logic              line_start,
   input  logic              pix_adv,
   input  logic              cfg_region_we,
   input  logic [RIW-1:0]    cfg_region_idx,
   input  logic [LW-1:0]     cfg_region_lines,
   input  logic [ADDR_W-1:0] cfg_region_base,
   input  logic [ADDR_W-1:0] cfg_region_stride,
   input  logic              cfg_frame_we,
   input  logic [FSW-1:0]    cfg_frame_sel,
   input  logic              cfg_pan_we,
   input  logic [CW-1:0]     cfg_pan_x,
   input  logic [CW-1:0]     cfg_pan_y,
   input  logic              cfg_mode_we,
   input  logic              cfg_flip_h,
   input  logic              cfg_flip_v,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_valid_o,
   output logic              cfg_err_o,
   output logic [FSW-1:0]    frame_o
);
   localparam int RW  = width_for(PANEL_H);
   localparam int CXW = width_for(PANEL_W);

   initial begin
      assert (FRAME_W >= PANEL_W && FRAME_H >= PANEL_H) else $error("frame smaller than panel");
      assert (N_REGIONS >= 1 && N_FRAMES >= 1) else $error("need at least one strip and frame");
      assert (ADDR_W >= 2) else $error("address too narrow");
   end

   logic [LW-1:0]     act_lines  [N_REGIONS];
   logic [ADDR_W-1:0] act_base   [N_REGIONS];
   logic [ADDR_W-1:0] act_stride [N_REGIONS];
   logic [CW-1:0]     act_pan_x, act_pan_y;
   scan_order_t       act_order, mode_in;
   logic [RW-1:0]     mem_row;
   logic [CXW-1:0]    mem_col;
   logic              line_live, last_pix;

   assign mode_in = '{flip_h: cfg_flip_h, flip_v: cfg_flip_v};

   fbscan_cfg_bank #(.ADDR_W(ADDR_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .FRAME_W(FRAME_W),
                     .FRAME_H(FRAME_H), .N_FRAMES(N_FRAMES), .N_REGIONS(N_REGIONS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .commit(vblank_start),
      .region_we(cfg_region_we), .region_idx(cfg_region_idx), .region_lines(cfg_region_lines),
      .region_base(cfg_region_base), .region_stride(cfg_region_stride),
      .frame_we(cfg_frame_we), .frame_sel(cfg_frame_sel),
      .pan_we(cfg_pan_we), .pan_x(cfg_pan_x), .pan_y(cfg_pan_y),
      .mode_we(cfg_mode_we), .mode_in(mode_in),
      .act_lines(act_lines), .act_base(act_base), .act_stride(act_stride),
      .act_frame(frame_o), .act_pan_x(act_pan_x), .act_pan_y(act_pan_y),
      .act_order(act_order), .err_o(cfg_err_o));

   fbscan_raster #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_raster (
      .clk(clk), .rst_n(rst_n), .frame_start(vblank_start), .line_start(line_start),
      .pix_adv(pix_adv), .order(act_order), .mem_row(mem_row), .mem_col(mem_col),
      .line_live(line_live), .last_pix(last_pix));

   fbscan_addr_map #(.ADDR_W(ADDR_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .FRAME_W(FRAME_W),
                     .FRAME_H(FRAME_H), .N_FRAMES(N_FRAMES), .N_REGIONS(N_REGIONS)) u_map (
      .mem_row(mem_row), .mem_col(mem_col), .line_live(line_live),
      .lines(act_lines), .base(act_base), .stride(act_stride),
      .frame(frame_o), .pan_x(act_pan_x), .pan_y(act_pan_y),
      .addr(addr_o), .valid(addr_valid_o));

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid_o && pix_adv && !last_pix && !line_start && !vblank_start |=>
      addr_o == (act_order.flip_h ? $past(addr_o) - ADDR_W'(1) : $past(addr_o) + ADDR_W'(1)));
   a_r6_odd_base: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_region_we && cfg_region_base[0] |=> cfg_err_o);
endmodule

// File: tb/fb_scan_addr_gen_test.sv
module fb_scan_addr_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, PW = 4, PH = 4, FW = 6, FH = 5, NF = 2, NR = 2;

   logic clk = 0, rst_n = 0;
   logic vblank_start = 0, line_start = 0, pix_adv = 0;
   logic cfg_region_we = 0, cfg_frame_we = 0, cfg_pan_we = 0, cfg_mode_we = 0;
   logic [1:0]  cfg_region_idx = 0;
   logic [2:0]  cfg_region_lines = 0;
   logic [15:0] cfg_region_base = 0, cfg_region_stride = 0;
   logic [1:0]  cfg_frame_sel = 0;
   logic [2:0]  cfg_pan_x = 0, cfg_pan_y = 0;
   logic cfg_flip_h = 0, cfg_flip_v = 0;
   logic [15:0] addr_o;
   logic addr_valid_o, cfg_err_o;
   logic [1:0] frame_o;
   logic f_pan_we = 0;
   logic [15:0] f_addr;
   logic f_valid, f_err;
   logic [0:0] f_frame;

   int checks = 0, fails = 0;
   // bench model of shadow (s_) and active (a_) settings
   int s_lines[NR], s_base[NR], s_stride[NR], s_frame, s_px, s_py, s_fh, s_fv;
   int a_lines[NR], a_base[NR], a_stride[NR], a_frame, a_px, a_py, a_fh, a_fv;

   always #(CLK_PERIOD/2) clk = ~clk;

   fb_scan_addr_gen #(.ADDR_W(AW), .PANEL_W(PW), .PANEL_H(PH), .FRAME_W(FW), .FRAME_H(FH),
                      .N_FRAMES(NF), .N_REGIONS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start), .line_start(line_start),
      .pix_adv(pix_adv), .cfg_region_we(cfg_region_we), .cfg_region_idx(cfg_region_idx),
      .cfg_region_lines(cfg_region_lines), .cfg_region_base(cfg_region_base),
      .cfg_region_stride(cfg_region_stride), .cfg_frame_we(cfg_frame_we),
      .cfg_frame_sel(cfg_frame_sel), .cfg_pan_we(cfg_pan_we), .cfg_pan_x(cfg_pan_x),
      .cfg_pan_y(cfg_pan_y), .cfg_mode_we(cfg_mode_we), .cfg_flip_h(cfg_flip_h),
      .cfg_flip_v(cfg_flip_v), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
      .cfg_err_o(cfg_err_o), .frame_o(frame_o));

   // frame equal to panel: only the origin is a legal pan
   fb_scan_addr_gen #(.ADDR_W(AW), .PANEL_W(PW), .PANEL_H(PH), .FRAME_W(PW), .FRAME_H(PH),
                      .N_FRAMES(1), .N_REGIONS(1)) uut_flat (
      .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start), .line_start(1'b0),
      .pix_adv(1'b0), .cfg_region_we(1'b0), .cfg_region_idx(1'b0),
      .cfg_region_lines(3'd0), .cfg_region_base(16'd0), .cfg_region_stride(16'd0),
      .cfg_frame_we(1'b0), .cfg_frame_sel(1'b0), .cfg_pan_we(f_pan_we),
      .cfg_pan_x(cfg_pan_x), .cfg_pan_y(cfg_pan_y), .cfg_mode_we(1'b0),
      .cfg_flip_h(1'b0), .cfg_flip_v(1'b0), .addr_o(f_addr), .addr_valid_o(f_valid),
      .cfg_err_o(f_err), .frame_o(f_frame));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   function automatic void expect_pix(input int s, input int p, output bit v, output int a);
      int m, c, first;
      m = a_fv ? s : PH - 1 - s;
      c = a_fh ? PW - 1 - p : p;
      first = 0; v = 0; a = 0;
      for (int k = 0; k < NR; k++) begin
         if (!v && m >= first && m < first + a_lines[k]) begin
            v = 1;
            a = (a_frame * FW * FH + a_base[k] + (m - first + a_py) * a_stride[k] + c + a_px) & 16'hffff;
         end
         first += a_lines[k];
      end
   endfunction

   task automatic do_vblank();
      vblank_start = 1;
      @(posedge clk); #1 vblank_start = 0;
      a_lines = s_lines; a_base = s_base; a_stride = s_stride;
      a_frame = s_frame; a_px = s_px; a_py = s_py; a_fh = s_fh; a_fv = s_fv;
   endtask

   task automatic scan_line(input int s, input string req);
      bit v; int a;
      line_start = 1;
      @(posedge clk); #1 line_start = 0;
      for (int p = 0; p < PW; p++) begin
         @(negedge clk);
         expect_pix(s, p, v, a);
         check(req, addr_valid_o, v);
         if (v) check(req, addr_o, a);
         pix_adv = 1;
         @(posedge clk); #1 pix_adv = 0;
      end
      @(negedge clk);
      check(req, addr_valid_o, 0);
   endtask

   task automatic scan_frame(input string req);
      do_vblank();
      for (int s = 0; s < PH; s++) scan_line(s, req);
   endtask

   task automatic wr_region(input int idx, lines, base, stride, input bit ok, input string req);
      cfg_region_we = 1; cfg_region_idx = 2'(idx); cfg_region_lines = 3'(lines);
      cfg_region_base = 16'(base); cfg_region_stride = 16'(stride);
      @(posedge clk); #1 cfg_region_we = 0;
      @(negedge clk);
      check(req, cfg_err_o, !ok);
      if (ok) begin s_lines[idx] = lines; s_base[idx] = base; s_stride[idx] = stride; end
   endtask

   task automatic wr_pan(input int x, y, input bit ok, input string req);
      cfg_pan_we = 1; cfg_pan_x = 3'(x); cfg_pan_y = 3'(y);
      @(posedge clk); #1 cfg_pan_we = 0;
      @(negedge clk);
      check(req, cfg_err_o, !ok);
      if (ok) begin s_px = x; s_py = y; end
   endtask

   task automatic wr_frame(input int f, input bit ok, input string req);
      cfg_frame_we = 1; cfg_frame_sel = 2'(f);
      @(posedge clk); #1 cfg_frame_we = 0;
      @(negedge clk);
      check(req, cfg_err_o, !ok);
      if (ok) s_frame = f;
   endtask

   task automatic wr_mode(input bit fh, input bit fv);
      cfg_mode_we = 1; cfg_flip_h = fh; cfg_flip_v = fv;
      @(posedge clk); #1 cfg_mode_we = 0;
      s_fh = fh; s_fv = fv;
   endtask

   task automatic t_reset();  // R1
      @(negedge clk);
      check("R1 valid", addr_valid_o, 0);
      check("R1 err", cfg_err_o, 0);
      check("R1 frame", frame_o, 0);
   endtask

   task automatic t_default();
      scan_frame("R2");
   endtask

   task automatic t_regions();
      do_vblank();
      wr_region(1, 2, 200, 6, 0, "R7 sum");
      wr_region(0, 2, 100, 8, 1, "R7");
      wr_region(1, 2, 200, 6, 1, "R7");
      for (int s = 0; s < PH; s++) scan_line(s, "R10 old setup");
      scan_frame("R3");
   endtask

   task automatic t_flip();
      wr_mode(1, 1);
      scan_frame("R4");
   endtask

   task automatic t_pan_frame();
      wr_pan(3, 0, 0, "R8 x");
      wr_pan(0, 2, 0, "R8 y");
      wr_pan(2, 1, 1, "R8");
      wr_frame(2, 0, "R9 range");
      wr_frame(1, 1, "R9");
      check("R10 frame held", frame_o, 0);
      scan_frame("R8");
      check("R9 readback", frame_o, 1);
   endtask

   task automatic t_odd();
      wr_region(0, 2, 101, 8, 0, "R6");
      scan_frame("R6");
   endtask

   task automatic t_counts();
      wr_region(0, 0, 100, 8, 0, "R7 zero");
      wr_region(0, 5, 100, 8, 0, "R7 tall");
      wr_region(2, 1, 100, 8, 0, "R7 idx");
      wr_region(0, 1, 100, 8, 1, "R7");
      wr_mode(0, 0);
      scan_frame("R5");
   endtask

   task automatic t_extra();
      scan_line(PH, "R11");
      scan_line(PH + 1, "R11");
   endtask

   task automatic t_flat();
      f_pan_we = 1; cfg_pan_x = 1; cfg_pan_y = 0;
      @(posedge clk); #1 f_pan_we = 0;
      @(negedge clk); check("R8 flat reject", f_err, 1);
      f_pan_we = 1; cfg_pan_x = 0; cfg_pan_y = 0;
      @(posedge clk); #1 f_pan_we = 0;
      @(negedge clk); check("R8 flat origin", f_err, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      for (int k = 0; k < NR; k++) begin
         s_lines[k] = (k == 0) ? PH : 0; s_base[k] = 0; s_stride[k] = FW;
      end
      s_frame = 0; s_px = 0; s_py = 0; s_fh = 0; s_fv = 0;
      a_lines = s_lines; a_base = s_base; a_stride = s_stride;
      a_frame = 0; a_px = 0; a_py = 0; a_fh = 0; a_fv = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_default();
      t_regions();
      t_flip();
      t_pan_frame();
      t_odd();
      t_counts();
      t_extra();
      t_flat();
      finish_run();
   end
endmodule